// File: doc/BRIEF.md
# Bus Ready Merge Unit

This block combines two ready sources into the single active-low ready line that a bus master and its bus controller sample together. Both agents see one registered line, so they end a bus cycle at the same clock edge. The first source is a synchronous ready that already meets setup and hold at the system clock. The second source comes from a foreign clock domain and must be resolved before the block uses it.

A bus state takes two system clocks. `phase_one` is high during the first of them, and `cmd_state` is high for the whole of a command state. The block samples the synchronous ready at the edge that ends phase one of a command state. The asynchronous ready goes through a capture flop at the edge that opens the command state and gets one full clock to settle. It then enters the output flop at the same edge as the synchronous sample. The merged ready is therefore low for phase two of the command state, which makes it valid at the edge that ends that state. It returns high at that edge.

Top module: `ready_merge`

## Requirements
- R1: While `rst_n` is low, `bus_rdy_n` is high, even if the other inputs would otherwise assert ready.
- R2: If `sync_rdy_n` is low at a rising edge where `cmd_state` and `phase_one` are both high, `bus_rdy_n` is low during the next clock cycle.
- R3: A low `sync_rdy_n` has no effect at any edge other than the one that ends phase one of a command state.
- R4: If `async_rdy_n` is low at the edge that opens a command state, `bus_rdy_n` is low during the clock that follows the command state's phase-one edge. That opening edge is the one just before the phase-one edge. The input passes through two flops: the capture flop and the output flop.
- R5: A low `async_rdy_n` has no effect on the current command state when it is seen only at the phase-one edge.
- R6: Ready is asserted when either qualified source is active, and also when both are active.
- R7: `bus_rdy_n` stays low for exactly one clock and is high again after the edge that ends the terminating command state.
- R8: After any edge where `cmd_state` and `phase_one` are not both high, `bus_rdy_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_one | input | 1 | High during the first clock of each bus state |
| cmd_state | input | 1 | High during a command state |
| sync_rdy_n | input | 1 | Synchronous ready, active low |
| async_rdy_n | input | 1 | Ready from a foreign clock domain, active low |
| bus_rdy_n | output | 1 | Merged ready to master and controller, active low |

## Verification
Inputs are sampled in the clock in which the bench drives them, and the merged ready is due one clock later, during phase two. The only exception is the asynchronous ready. It is taken from the cycle just before phase one, so its result appears two clocks after it was driven.

For every clock it drives, the driver queues the value that `bus_rdy_n` must show after the next rising edge. It computes the ready of a phase-one clock from the synchronous input of that clock and the asynchronous input of the clock before. The monitor samples one time unit after each rising edge and compares the sample with the oldest queued value.

// File: rtl/ready_merge.sv
module ready_merge (
  input  logic clk,
  input  logic rst_n,
  input  logic phase_one,
  input  logic cmd_state,
  input  logic sync_rdy_n,
  input  logic async_rdy_n,
  output logic bus_rdy_n
);

  logic async_q;
  logic rdy_q;
  logic sample_edge;

  assign sample_edge = cmd_state & phase_one;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      async_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      async_q <= ~async_rdy_n;
      rdy_q   <= sample_edge & (~sync_rdy_n | async_q);
    end
  end

  assign bus_rdy_n = ~rdy_q;

endmodule

// File: rtl/ready_merge_chk.sv
module ready_merge_chk (
  input logic clk,
  input logic rst_n,
  input logic phase_one,
  input logic cmd_state,
  input logic sync_rdy_n,
  input logic async_rdy_n,
  input logic bus_rdy_n
);

  logic armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R2
  sync_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_state && phase_one && !sync_rdy_n) |=> !bus_rdy_n);

  // R4
  async_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_state && phase_one && !$past(async_rdy_n)) |=> !bus_rdy_n);

  // R5
  no_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && cmd_state && phase_one && sync_rdy_n && $past(async_rdy_n)) |=> bus_rdy_n);

  // R7
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rdy_n |=> bus_rdy_n);

  // R8
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_state && phase_one) |=> bus_rdy_n);

endmodule

bind ready_merge ready_merge_chk u_ready_merge_chk (
  .clk(clk),
  .rst_n(rst_n),
  .phase_one(phase_one),
  .cmd_state(cmd_state),
  .sync_rdy_n(sync_rdy_n),
  .async_rdy_n(async_rdy_n),
  .bus_rdy_n(bus_rdy_n)
);

// File: tb/test_ready_merge.sv
`timescale 1ns/1ps
module test_ready_merge;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phase_one = 1'b0;
  logic cmd_state = 1'b0;
  logic sync_rdy_n = 1'b1;
  logic async_rdy_n = 1'b1;
  logic bus_rdy_n;

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails = 0;
  logic prev_async = 1'b1;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ready_merge i_ready_merge (
    .clk(clk), .rst_n(rst_n), .phase_one(phase_one), .cmd_state(cmd_state),
    .sync_rdy_n(sync_rdy_n), .async_rdy_n(async_rdy_n), .bus_rdy_n(bus_rdy_n)
  );

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: bus_rdy_n=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus state: P1 clock then P2 clock
  task automatic run_state(input logic is_cmd, input logic s1, input logic s2,
                           input logic a1, input logic a2, input string tag);
    item_t it;
    @(negedge clk);
    phase_one = 1'b1; cmd_state = is_cmd; sync_rdy_n = s1; async_rdy_n = a1;
    it.exp = ~(is_cmd & (~s1 | ~prev_async));
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    phase_one = 1'b0; sync_rdy_n = s2; async_rdy_n = a2;
    it.exp = 1'b1;
    it.tag = "R7";
    q.push_back(it);
    prev_async = a2;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        check(bus_rdy_n, it.exp, it.tag);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    phase_one = 1'b1; cmd_state = 1'b1; sync_rdy_n = 1'b0; async_rdy_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(bus_rdy_n, 1'b1, "R1");
    end
    async_rdy_n = 1'b1; sync_rdy_n = 1'b1; phase_one = 1'b0; cmd_state = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    prev_async = 1'b1;

    run_state(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8");
    run_state(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    run_state(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R2");
    run_state(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, "R3");
    run_state(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R3");
    run_state(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R4");
    run_state(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    run_state(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R5");
    run_state(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, "R6");
    run_state(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    run_state(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, "R7");
    run_state(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R2");
    run_state(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R8");

    for (int i = 0; i < 64; i++) begin
      logic [4:0] v;
      v = 5'(i * 7 + 3);
      run_state(v[0] | v[4], v[1], v[2], v[3], v[4] ^ v[1], "R6");
    end

    run_state(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, "R8");
    wait (q.size() == 0);
    @(negedge clk);
    phase_one = 1'b1; cmd_state = 1'b1; sync_rdy_n = 1'b0;
    rst_n = 1'b0;
    #1 check(bus_rdy_n, 1'b1, "R1");
    @(negedge clk);
    check(bus_rdy_n, 1'b1, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule